// File: doc/BRIEF.md
# Single-Wire Pulse-Width Slot Receiver

This block is the slave side of a one-wire bus. The master starts every bit slot by pulling the shared line low. The length of that low pulse carries the bit. The receiver waits a fixed number of local clock cycles after each falling edge and then samples the line. A short pulse has already ended by that point and reads as 1. A low that lasts past the sample point reads as 0. The received bits are collected into a frame word.

Frames are delimited by silence. The slot timer starts on a falling edge and keeps counting after the sample. If no further edge arrives before a longer timeout, the frame is closed: the bit count and the collected word are presented with a one-cycle strobe, and the internal collection is cleared. After the timeout the timer stops and stays stopped until the next edge, so the counting logic is idle whenever the bus is quiet.

The slave can also send data through the same slots. In response mode, to send a 0 it pulls the open-drain line low from the slot edge until its own sample point. On the wired line this stretches the master's short pulse into a long one.

Top module: `pwm_slot_rx`

## Requirements
- R1: After reset, every strobe output (bit_valid_o, frame_start_o, frame_end_o, slot_err_o) is low, line_pull_o is low, and frame_bits_o and frame_data_o are zero.
- R2: Each slot produces exactly one bit_valid_o pulse, SAMPLE_DLY clocks after its falling edge is detected. bit_o is 1 if the line has returned high by then and 0 if it is still low.
- R3: Within a frame, the k-th received bit (counting from 0) is placed at bit position k of frame_data_o, so the first bit is the LSB. Positions that received no bit read 0.
- R4: When FRAME_TMO clocks pass with no falling edge, frame_end_o pulses once with frame_bits_o equal to the number of bits stored. The next frame then starts with an empty word and a zero count.
- R5: frame_start_o pulses on the first falling edge seen while the timer is stopped. It does not pulse on later edges inside the same frame.
- R6: While the timer is stopped, no bit_valid_o, frame_end_o or slot_err_o pulse occurs. A single quiet period yields exactly one frame_end_o.
- R7: A falling edge that arrives before the running slot reaches its sample point raises slot_err_o for one cycle. The interrupted slot yields no bit, and timing restarts from the new edge.
- R8: If resp_en_i is 1 and resp_bit_i is 0 when a slot edge is detected, line_pull_o goes high on the next clock and stays high through that slot's sample, then drops. With resp_bit_i equal to 1, or resp_en_i equal to 0, line_pull_o stays low.
- R9: Bits beyond MAX_BITS in one frame are still reported on bit_valid_o/bit_o but are not stored. frame_bits_o saturates at MAX_BITS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local timing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_i | input | 1 | Raw level of the shared bus line (asynchronous) |
| resp_en_i | input | 1 | Enables slave response in the next slot |
| resp_bit_i | input | 1 | Bit the slave sends when responding (0 means pull low) |
| line_pull_o | output | 1 | Drives the open-drain pull-down of the line |
| bit_valid_o | output | 1 | One-cycle strobe: a slot was sampled |
| bit_o | output | 1 | Sampled bit value, valid with bit_valid_o |
| frame_start_o | output | 1 | One-cycle strobe on the first edge after idle |
| frame_end_o | output | 1 | One-cycle strobe on the idle timeout |
| frame_bits_o | output | $clog2(MAX_BITS+1) | Number of bits stored in the closed frame |
| frame_data_o | output | MAX_BITS | Collected frame word, first bit in the LSB |
| slot_err_o | output | 1 | One-cycle strobe: an edge arrived before the sample point |

## Verification
Some properties are checked on every cycle. Bit strobes, frame ends and slot errors never appear while the timer is stopped. A frame start only ever comes out of the stopped state. A frame end never coincides with a bit or a start, and its count never exceeds MAX_BITS. The pull-down is only ever released together with a sample or a slot error. Other behaviour can only be shown by the bench's scenarios: the actual value decoded from short and long pulses, the bit order in the frame word, clearing between frames, saturation on long frames, loss of an interrupted slot, and the way a slave response turns a master's 1 pulse into a 0 on the wired line.

// File: rtl/pwm_rx_pkg.sv
// Shared types for the single-wire slot receiver.
package pwm_rx_pkg;
    // Slot timer run state: stopped while the bus is quiet, running after an edge.
    typedef enum logic {
        TMR_STOPPED = 1'b0,
        TMR_RUNNING = 1'b1
    } tmr_state_e;
endpackage

// File: rtl/pwm_line_sync.sv
// Brings the asynchronous bus level into the clock domain through STAGES flops
// and flags falling edges of the synchronised level.
// Assumes an idle-high bus, so every flop resets to 1.
module pwm_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o,
    output logic fall_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First flop captures the raw pin.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[g] <= 1'b1;
                else        sync_q[g] <= line_i;
            end
        end else begin : g_next
            // Later flops resolve metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[g] <= 1'b1;
                else        sync_q[g] <= sync_q[g-1];
            end
        end
    end

    // Remember the last synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign line_o = sync_q[STAGES-1];
    assign fall_o = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/pwm_slot_timer.sv
// Gated slot timer. A falling edge starts it (or restarts it) at count 1. It
// flags the sample point at SAMPLE_DLY and the frame timeout at FRAME_TMO,
// then stops until the next edge.
// Assumes FRAME_TMO is larger than one full slot, and so larger than SAMPLE_DLY.
module pwm_slot_timer
    import pwm_rx_pkg::*;
#(
    parameter int SAMPLE_DLY = 20,
    parameter int FRAME_TMO  = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fall_i,
    output logic sample_o,
    output logic timeout_o,
    output logic early_o,
    output logic start_o
);
    localparam int CW = $clog2(FRAME_TMO + 1);
    localparam logic [CW-1:0] SAMPLE_AT = CW'(SAMPLE_DLY);
    localparam logic [CW-1:0] TMO_AT    = CW'(FRAME_TMO);

    tmr_state_e    state_q;
    logic [CW-1:0] cnt_q;
    logic          running;

    assign running = (state_q == TMR_RUNNING);

    // Count clocks since the last edge; stop at the frame timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TMR_STOPPED;
            cnt_q   <= '0;
        end else if (fall_i) begin
            state_q <= TMR_RUNNING;
            cnt_q   <= CW'(1);
        end else if (running) begin
            if (cnt_q == TMO_AT) begin
                state_q <= TMR_STOPPED;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    assign sample_o  = running && (cnt_q == SAMPLE_AT);
    assign timeout_o = running && (cnt_q == TMO_AT) && !fall_i;
    assign early_o   = fall_i && running && (cnt_q < SAMPLE_AT);
    assign start_o   = fall_i && !running;
endmodule

// File: rtl/pwm_bit_collector.sv
// Collects sampled bits into a frame word, LSB first, and closes the frame on
// timeout: it presents the count and the word with a strobe, then clears.
// Assumes sample and timeout never fall in the same cycle.
module pwm_bit_collector #(
    parameter int MAX_BITS = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sample_i,
    input  logic                        line_i,
    input  logic                        timeout_i,
    output logic                        bit_valid_o,
    output logic                        bit_o,
    output logic                        frame_end_o,
    output logic [$clog2(MAX_BITS+1)-1:0] frame_bits_o,
    output logic [MAX_BITS-1:0]         frame_data_o
);
    localparam int BW = $clog2(MAX_BITS + 1);
    localparam logic [BW-1:0] FULL = BW'(MAX_BITS);

    logic [BW-1:0]       count_q;
    logic [MAX_BITS-1:0] data_q;

    // Track the number of stored bits, saturating at MAX_BITS.
    always_ff @(posedge clk) begin
        if (!rst_n || timeout_i)             count_q <= '0;
        else if (sample_i && count_q != FULL) count_q <= count_q + BW'(1);
    end

    for (genvar i = 0; i < MAX_BITS; i++) begin : g_slot_bit
        // Each word position captures the sample whose index matches it.
        always_ff @(posedge clk) begin
            if (!rst_n || timeout_i)                     data_q[i] <= 1'b0;
            else if (sample_i && count_q == BW'(i))      data_q[i] <= line_i;
        end
    end

    // Register the per-slot result strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_valid_o <= 1'b0;
            bit_o       <= 1'b0;
        end else begin
            bit_valid_o <= sample_i;
            if (sample_i) bit_o <= line_i;
        end
    end

    // Present the closed frame on timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_end_o  <= 1'b0;
            frame_bits_o <= '0;
            frame_data_o <= '0;
        end else begin
            frame_end_o <= timeout_i;
            if (timeout_i) begin
                frame_bits_o <= count_q;
                frame_data_o <= data_q;
            end
        end
    end
endmodule

// File: rtl/pwm_slot_rx.sv
// Top of the single-wire slot receiver: synchroniser, gated slot timer, bit
// collector and open-drain response driver.
// Assumes an idle-high wired bus whose level, including this block's own pull,
// is fed back on line_i.
module pwm_slot_rx #(
    parameter int SYNC_STAGES = 2,
    parameter int SAMPLE_DLY  = 20,
    parameter int FRAME_TMO   = 100,
    parameter int MAX_BITS    = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          line_i,
    input  logic                          resp_en_i,
    input  logic                          resp_bit_i,
    output logic                          line_pull_o,
    output logic                          bit_valid_o,
    output logic                          bit_o,
    output logic                          frame_start_o,
    output logic                          frame_end_o,
    output logic [$clog2(MAX_BITS+1)-1:0] frame_bits_o,
    output logic [MAX_BITS-1:0]           frame_data_o,
    output logic                          slot_err_o
);
    logic line_s, fall, sample, timeout, early, start;

    pwm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (line_i),
        .line_o (line_s),
        .fall_o (fall)
    );

    pwm_slot_timer #(.SAMPLE_DLY(SAMPLE_DLY), .FRAME_TMO(FRAME_TMO)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall_i    (fall),
        .sample_o  (sample),
        .timeout_o (timeout),
        .early_o   (early),
        .start_o   (start)
    );

    pwm_bit_collector #(.MAX_BITS(MAX_BITS)) u_coll (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_i     (sample),
        .line_i       (line_s),
        .timeout_i    (timeout),
        .bit_valid_o  (bit_valid_o),
        .bit_o        (bit_o),
        .frame_end_o  (frame_end_o),
        .frame_bits_o (frame_bits_o),
        .frame_data_o (frame_data_o)
    );

    // Register the frame-start and early-edge strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_start_o <= 1'b0;
            slot_err_o    <= 1'b0;
        end else begin
            frame_start_o <= start;
            slot_err_o    <= early;
        end
    end

    // Hold the line low from the slot edge through the sample when sending a 0.
    always_ff @(posedge clk) begin
        if (!rst_n)      line_pull_o <= 1'b0;
        else if (fall)   line_pull_o <= resp_en_i & ~resp_bit_i;
        else if (sample) line_pull_o <= 1'b0;
    end
endmodule

// File: rtl/pwm_slot_rx_chk.sv
// Cycle-by-cycle protocol checks on the receiver's outputs, bound to the top.
// Tracks the stopped/running phase from the start and end strobes.
module pwm_slot_rx_chk #(
    parameter int MAX_BITS = 16
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          line_pull_o,
    input logic                          bit_valid_o,
    input logic                          frame_start_o,
    input logic                          frame_end_o,
    input logic [$clog2(MAX_BITS+1)-1:0] frame_bits_o,
    input logic                          slot_err_o
);
    logic idle_q;

    // Follow the idle phase: set by a frame end, cleared by a frame start.
    always_ff @(posedge clk) begin
        if (!rst_n)             idle_q <= 1'b1;
        else if (frame_start_o) idle_q <= 1'b0;
        else if (frame_end_o)   idle_q <= 1'b1;
    end

    a_r6_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        idle_q |-> (!bit_valid_o && !frame_end_o && !slot_err_o));

    a_r5_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |-> idle_q);

    a_r4_end_alone: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end_o |-> (!bit_valid_o && !frame_start_o));

    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end_o |-> (frame_bits_o <= ($clog2(MAX_BITS+1))'(MAX_BITS)));

    a_r8_pull_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_pull_o) |-> (bit_valid_o || slot_err_o));

    a_r7_err_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        slot_err_o |-> !idle_q);
endmodule

bind pwm_slot_rx pwm_slot_rx_chk #(.MAX_BITS(MAX_BITS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .line_pull_o   (line_pull_o),
    .bit_valid_o   (bit_valid_o),
    .frame_start_o (frame_start_o),
    .frame_end_o   (frame_end_o),
    .frame_bits_o  (frame_bits_o),
    .slot_err_o    (slot_err_o)
);

// File: tb/sim_pwm_slot_rx.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks push expected bits and frames, a monitor pops
// and compares them as the receiver produces results.
module sim_pwm_slot_rx;
    localparam int SD   = 20;
    localparam int TMO  = 100;
    localparam int MB   = 16;
    localparam int BW   = $clog2(MB + 1);
    localparam int SLOT = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic master_n = 1'b1;
    logic resp_en = 1'b0;
    logic resp_bit = 1'b1;
    logic pull, bit_valid, bit_v, f_start, f_end, s_err;
    logic [BW-1:0] f_bits;
    logic [MB-1:0] f_data;
    logic line;

    assign line = master_n & ~pull;  // wired bus: either side can pull low

    always #2.5 clk = ~clk;

    pwm_slot_rx #(.SYNC_STAGES(2), .SAMPLE_DLY(SD), .FRAME_TMO(TMO), .MAX_BITS(MB)) u0 (
        .clk(clk), .rst_n(rst_n), .line_i(line), .resp_en_i(resp_en), .resp_bit_i(resp_bit),
        .line_pull_o(pull), .bit_valid_o(bit_valid), .bit_o(bit_v),
        .frame_start_o(f_start), .frame_end_o(f_end), .frame_bits_o(f_bits),
        .frame_data_o(f_data), .slot_err_o(s_err)
    );

    int checks = 0, fails = 0;
    int n_start = 0, n_end = 0, n_err = 0, n_bit = 0;
    logic          bit_q[$];
    logic [BW-1:0] cnt_q[$];
    logic [MB-1:0] dat_q[$];
    logic [BW-1:0] acc_cnt = '0;
    logic [MB-1:0] acc_dat = '0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expect one bit and record it into the running frame model.
    task automatic expect_bit(input logic b);
        bit_q.push_back(b);
        if (acc_cnt < BW'(MB)) begin
            acc_dat[acc_cnt] = b;
            acc_cnt = acc_cnt + BW'(1);
        end
    endtask

    // Master drives one slot with the given low time.
    task automatic drive_slot(input int low_len);
        @(posedge clk); #1 master_n = 1'b0;
        repeat (low_len) @(posedge clk);
        #1 master_n = 1'b1;
        repeat (SLOT - low_len) @(posedge clk);
    endtask

    task automatic send(input logic b);
        expect_bit(b);
        drive_slot(b ? 4 : 35);
    endtask

    // Master sends a short pulse while the slave answers with rb (R8).
    task automatic send_resp(input logic rb);
        resp_en = 1'b1; resp_bit = rb;
        expect_bit(rb);
        @(posedge clk); #1 master_n = 1'b0;
        repeat (4) @(posedge clk);
        #1 master_n = 1'b1;
        repeat (8) @(posedge clk);
        #1 check(pull == !rb, "R8 pull during slot", pull, !rb);
        repeat (SLOT - 12) @(posedge clk);
        #1 check(pull == 1'b0, "R8 pull released after sample", pull, 0);
        resp_en = 1'b0; resp_bit = 1'b1;
    endtask

    // Queue the expected frame result, then let the bus go quiet.
    task automatic close_frame();
        cnt_q.push_back(acc_cnt);
        dat_q.push_back(acc_dat);
        acc_cnt = '0;
        acc_dat = '0;
        repeat (3 * SLOT) @(posedge clk);
    endtask

    // Monitor: compare strobed results against the scoreboard queues.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (bit_valid) begin
                n_bit++;
                if (bit_q.size() == 0) check(0, "R2 unexpected bit", bit_v, -1);
                else begin
                    logic e;
                    e = bit_q.pop_front();
                    check(bit_v == e, "R2 decoded bit", bit_v, e);
                end
            end
            if (f_end) begin
                n_end++;
                if (cnt_q.size() == 0) check(0, "R4 unexpected frame end", f_bits, -1);
                else begin
                    logic [BW-1:0] ec;
                    logic [MB-1:0] ed;
                    ec = cnt_q.pop_front();
                    ed = dat_q.pop_front();
                    check(f_bits == ec, "R4/R9 frame bit count", f_bits, ec);
                    check(f_data == ed, "R3 frame word", f_data, ed);
                end
            end
            if (f_start) n_start++;
            if (s_err)   n_err++;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            check(0, "watchdog expired", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check({bit_valid, f_start, f_end, s_err, pull} == 5'b0, "R1 strobes idle",
              {bit_valid, f_start, f_end, s_err, pull}, 0);
        check(f_bits == 0 && f_data == 0, "R1 frame outputs zero", f_data, 0);

        // R2/R3: mixed pattern, first bit in LSB
        send(1); send(0); send(1); send(1); send(0); send(0); send(1); send(0);
        close_frame();
        check(n_start == 1, "R5 one start per frame", n_start, 1);
        check(n_end == 1, "R4 one end per frame", n_end, 1);

        // R4: short all-zero frame; upper word bits must be cleared
        send(0); send(0); send(0);
        close_frame();

        // R6: long quiet period yields nothing more
        repeat (300) @(posedge clk);
        #1 check(n_end == 2, "R6 no extra frame end while idle", n_end, 2);
        check(n_bit == 11, "R6 no bits while idle", n_bit, 11);

        // R8: slave response turns short pulses into zeros
        send_resp(0); send_resp(1); send_resp(0); send(1);
        close_frame();
        check(n_start == 3, "R5 start count after response frame", n_start, 3);

        // R7: early second edge is flagged and the first slot is dropped
        @(posedge clk); #1 master_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 master_n = 1'b1;
        repeat (7) @(posedge clk);
        send(0);
        send(1);
        close_frame();
        check(n_err == 1, "R7 slot error flagged once", n_err, 1);
        check(n_start == 4, "R7 early edge is not a new frame", n_start, 4);

        // R9: overflow beyond MAX_BITS
        for (int i = 0; i < MB + 2; i++) send((i % 3) == 0);
        close_frame();

        check(bit_q.size() == 0 && cnt_q.size() == 0, "R2/R4 scoreboard drained",
              bit_q.size() + cnt_q.size(), 0);
        check(n_bit == 11 + 4 + 2 + MB + 2, "R9 every slot reported", n_bit, 11 + 4 + 2 + MB + 2);
        check(n_end == 5, "R4 frame end total", n_end, 5);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule